// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the protocol engine of a small byte-wide non-volatile memory reached over a two-wire serial bus. It watches already filtered clock and data lines, recognises bus start and stop conditions, matches a 7-bit device address and then takes either a write or a read. A write sets the word pointer and collects up to eight data bytes in a page buffer. The STOP that closes the write launches a self-timed programming cycle, which copies every received slot of the buffer into the memory array through a synchronous write port. A read streams bytes from the word pointer until the master declines to acknowledge.

The array holds 128 or 256 bytes (`MEM_BYTES`). The programming cycle lasts `TWR_CYC` system clocks and is flagged on `busy_o`. Throughout that window the block answers no address, so a master can poll for completion. All decisions are taken on the system clock: the serial clock is oversampled and its edges are detected by comparison with the previous sample.

The controller states are IDLE, DEVSEL, DEV_ACK, WADDR, WADDR_ACK, WDATA, WDATA_ACK, RDATA, RD_ACK and HOLD. The transitions are:
- START enters DEVSEL from any state.
- STOP enters IDLE from any state.
- DEVSEL goes to DEV_ACK after a matching byte while not busy, and to HOLD otherwise.
- DEV_ACK goes to WADDR or RDATA, depending on the direction bit, after the acknowledge clock ends.
- WADDR goes to WADDR_ACK, and then to WDATA.
- WDATA goes to WDATA_ACK, and then back to WDATA.
- RDATA goes to RD_ACK after eight bits.
- RD_ACK goes back to RDATA on a master acknowledge, and to HOLD on a master not-acknowledge.
- HOLD leaves only on START or STOP.

Top module: `eep_twi_slave`

## Requirements
- R1: After reset, SDA is released (`sda_pull_o`=0), `busy_o` is 0 and no array write occurs.
- R2: A select byte is 7 address bits, MSB first, followed by a direction bit (0 = write, 1 = read). It is acknowledged only when the address equals `DEV_ADDR`. On a mismatch SDA stays released for the rest of the transfer.
- R3: For every byte received while addressed, SDA is pulled low from the SCL fall after the eighth bit until the SCL fall ending the ninth clock, so it is low for the whole ninth high period. SDA never changes while SCL stays high.
- R4: The word address byte sets the pointer, and bits at and above log2(`MEM_BYTES`) are ignored. Data bytes land at consecutive addresses whose low 3 bits wrap inside the 8-byte page. The commit writes only the received locations, and all of them fall in that one page.
- R5: When more than 8 data bytes arrive, each page slot holds the last byte sent to it, so newer bytes replace older ones in arrival order.
- R6: `busy_o` rises in the cycle after the STOP that ends a write carrying at least one complete data byte, and stays high for exactly `TWR_CYC` clocks. Array writes happen only while busy.
- R7: While `busy_o` is high the block acknowledges nothing and never pulls SDA.
- R8: A read sends bytes MSB first from the pointer. The pointer increments after each byte and wraps from `MEM_BYTES`-1 to 0.
- R9: After a master not-acknowledge, SDA stays released until the next START or STOP.
- R10: A START or STOP arriving with 2 to 7 bits of a byte shifted in aborts the transfer, and no programming cycle follows.
- R11: A write that carries only the word address and then ends with STOP starts no programming cycle and leaves the pointer for a later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Filtered, synchronised serial clock |
| sda_i | input | 1 | Filtered, synchronised serial data (wired bus level) |
| sda_pull_o | output | 1 | 1 = drive SDA low (open-drain pull-down) |
| mem_addr_o | output | log2(MEM_BYTES) | Array address (read pointer, or write address while busy) |
| mem_wdata_o | output | 8 | Array write data |
| mem_we_o | output | 1 | Array write enable |
| mem_rdata_i | input | 8 | Array read data, one clock after the address |
| busy_o | output | 1 | Programming cycle in progress |

## Verification
The bench builds the block with `MEM_BYTES`=128, `TWR_CYC`=400 and the device address 0x50. With 128 bytes the whole array can be filled by sixteen page writes and read back in one sequential pass, and that pass crosses the top-of-array wrap and exercises the ignored upper bit of the word address. With a 400-clock write cycle there is time to probe an address while the cycle is running, and the whole run, including a sweep over all 127 non-matching select addresses, stays short.

// File: rtl/eep_twi_pkg.sv
package eep_twi_pkg;

    // Controller states of the serial slave engine
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_HOLD
    } ctl_state_e;

    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/eep_line_mon.sv
// Edge and bus-condition detector on the oversampled two-wire lines.
module eep_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise  = scl_i & ~scl_q;
    assign scl_fall  = ~scl_i & scl_q;
    // data moving while the clock is high marks a bus condition
    assign bus_start = scl_i & scl_q & sda_q & ~sda_i;
    assign bus_stop  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/eep_page_buf.sv
// Page staging buffer: one byte register and one valid flag per slot.
module eep_page_buf #(
    parameter int PAGE_BYTES = 8,
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          wr_i,
    input  logic [PW-1:0] wr_idx_i,
    input  logic [7:0]    wr_data_i,
    input  logic [PW-1:0] rd_idx_i,
    output logic [7:0]    rd_data_o,
    output logic          rd_vld_o
);

    logic [7:0]            slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= 8'h00;
            end else if (wr_i && (wr_idx_i == PW'(g))) begin
                slot_q[g] <= wr_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (clr_i) begin
            vld_q <= '0;
        end else if (wr_i) begin
            vld_q[wr_idx_i] <= 1'b1;
        end
    end

    assign rd_data_o = slot_q[rd_idx_i];
    assign rd_vld_o  = vld_q[rd_idx_i];

endmodule

// File: rtl/eep_prog_seq.sv
// Self-timed programming cycle: walks the page slots during the first
// cycles of the window, then waits out the remaining time.
module eep_prog_seq #(
    parameter int AW         = 8,
    parameter int PAGE_BYTES = 8,
    parameter int TWR_CYC    = 2_500_000,
    localparam int PW = $clog2(PAGE_BYTES),
    localparam int BW = AW - PW,
    localparam int TW = $clog2(TWR_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic [BW-1:0] base_i,
    input  logic          slot_vld_i,
    output logic [PW-1:0] slot_idx_o,
    output logic [AW-1:0] waddr_o,
    output logic          we_o,
    output logic          busy_o,
    output logic          done_o
);

    localparam logic [TW-1:0] LAST_CYC  = TW'(TWR_CYC - 1);
    localparam logic [TW-1:0] SLOT_SPAN = TW'(PAGE_BYTES);

    logic [TW-1:0] tmr_q;
    logic [BW-1:0] base_q;
    logic          busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            tmr_q  <= '0;
            base_q <= '0;
        end else if (!busy_q) begin
            if (go_i) begin
                busy_q <= 1'b1;
                tmr_q  <= '0;
                base_q <= base_i;
            end
        end else begin
            tmr_q <= tmr_q + TW'(1);
            if (tmr_q == LAST_CYC) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign slot_idx_o = tmr_q[PW-1:0];
    assign waddr_o    = {base_q, tmr_q[PW-1:0]};
    assign we_o       = busy_q && (tmr_q < SLOT_SPAN) && slot_vld_i;
    assign busy_o     = busy_q;
    assign done_o     = busy_q && (tmr_q == LAST_CYC);

endmodule

// File: rtl/eep_twi_slave.sv
// Two-wire slave front end for a paged byte memory.
module eep_twi_slave
    import eep_twi_pkg::*;
#(
    parameter int          MEM_BYTES  = 256,
    parameter int          PAGE_BYTES = 8,
    parameter logic [6:0]  DEV_ADDR   = 7'h50,
    parameter int          TWR_CYC    = 2_500_000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scl_i,
    input  logic                         sda_i,
    output logic                         sda_pull_o,
    output logic [$clog2(MEM_BYTES)-1:0] mem_addr_o,
    output logic [7:0]                   mem_wdata_o,
    output logic                         mem_we_o,
    input  logic [7:0]                   mem_rdata_i,
    output logic                         busy_o
);

    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int BW = AW - PW;

    ctl_state_e state, nstate;

    logic          scl_rise, scl_fall, bus_start, bus_stop;
    logic [2:0]    bit_cnt;
    logic [7:0]    rx_sr, tx_sr;
    logic [7:0]    rx_byte;
    logic [1:0]    ph;
    logic          rd_mode;
    logic          got_data;
    logic [AW-1:0] ptr;
    logic          shift_st, byte_done, tx_done, dev_hit;
    logic          buf_wr, buf_clr, load_tx, prog_go;
    logic          busy_w, prog_done, prog_we, slot_vld;
    logic [PW-1:0] slot_idx;
    logic [AW-1:0] prog_addr;
    logic [7:0]    slot_data;

    eep_line_mon u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    eep_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (buf_clr),
        .wr_i      (buf_wr),
        .wr_idx_i  (ptr[PW-1:0]),
        .wr_data_i (rx_byte),
        .rd_idx_i  (slot_idx),
        .rd_data_o (slot_data),
        .rd_vld_o  (slot_vld)
    );

    eep_prog_seq #(
        .AW         (AW),
        .PAGE_BYTES (PAGE_BYTES),
        .TWR_CYC    (TWR_CYC)
    ) u_prog (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (prog_go),
        .base_i     (ptr[AW-1:PW]),
        .slot_vld_i (slot_vld),
        .slot_idx_o (slot_idx),
        .waddr_o    (prog_addr),
        .we_o       (prog_we),
        .busy_o     (busy_w),
        .done_o     (prog_done)
    );

    // ---------------- decode helpers ----------------
    assign shift_st  = (state == ST_DEVSEL) || (state == ST_WADDR) || (state == ST_WDATA);
    assign rx_byte   = {rx_sr[6:0], sda_i};
    assign byte_done = shift_st && scl_rise && (bit_cnt == 3'd7);
    assign tx_done   = (state == ST_RDATA) && scl_rise && (bit_cnt == 3'd7);
    assign dev_hit   = (rx_byte[7:1] == DEV_ADDR) && !busy_w;

    assign buf_wr    = (state == ST_WDATA) && byte_done && !bus_start && !bus_stop;
    assign buf_clr   = ((state == ST_WADDR) && byte_done) || prog_done;
    // a STOP right after a data-byte boundary sees exactly one clock rise
    assign prog_go   = bus_stop && (state == ST_WDATA) && (bit_cnt == 3'd1) && got_data;
    assign load_tx   = (nstate == ST_RDATA) && (state != ST_RDATA);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        nstate = state;
        if (bus_stop) begin
            nstate = ST_IDLE;
        end else if (bus_start) begin
            nstate = ST_DEVSEL;
        end else begin
            unique case (state)
                ST_IDLE:      nstate = ST_IDLE;
                ST_DEVSEL:    if (byte_done) nstate = dev_hit ? ST_DEV_ACK : ST_HOLD;
                ST_DEV_ACK:   if (scl_fall && ph == 2'd1) nstate = rd_mode ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (byte_done) nstate = ST_WADDR_ACK;
                ST_WADDR_ACK: if (scl_fall && ph == 2'd1) nstate = ST_WDATA;
                ST_WDATA:     if (byte_done) nstate = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall && ph == 2'd1) nstate = ST_WDATA;
                ST_RDATA:     if (tx_done) nstate = ST_RD_ACK;
                ST_RD_ACK: begin
                    if (scl_rise && ph == 2'd1 && sda_i) nstate = ST_HOLD;
                    else if (scl_fall && ph == 2'd2)     nstate = ST_RDATA;
                end
                ST_HOLD:      nstate = ST_HOLD;
                default:      nstate = ST_IDLE;
            endcase
        end
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sr    <= '0;
            tx_sr    <= 8'hFF;
            ph       <= '0;
            rd_mode  <= 1'b0;
            got_data <= 1'b0;
            ptr      <= '0;
        end else begin
            if (bus_start || bus_stop) begin
                bit_cnt <= '0;
            end else begin
                if (shift_st && scl_rise) begin
                    rx_sr   <= rx_byte;
                    bit_cnt <= bit_cnt + 3'd1;
                end
                if (state == ST_RDATA) begin
                    if (scl_rise) bit_cnt <= bit_cnt + 3'd1;
                    if (scl_fall) tx_sr <= {tx_sr[6:0], 1'b1};
                end
                if (state == ST_DEVSEL && byte_done) begin
                    rd_mode <= rx_byte[0];
                end
                if (state == ST_WADDR && byte_done) begin
                    ptr      <= rx_byte[AW-1:0];
                    got_data <= 1'b0;
                end
                if (buf_wr) begin
                    ptr      <= {ptr[AW-1:PW], ptr[PW-1:0] + PW'(1)};
                    got_data <= 1'b1;
                end
                if (tx_done) begin
                    ptr <= ptr + AW'(1);
                end
                if (load_tx) begin
                    tx_sr <= mem_rdata_i;
                end
            end

            // phase within acknowledge bits
            if (nstate != state) begin
                ph <= '0;
            end else if (state == ST_DEV_ACK || state == ST_WADDR_ACK || state == ST_WDATA_ACK) begin
                if (scl_fall) ph <= ph + 2'd1;
            end else if (state == ST_RD_ACK) begin
                if (scl_fall && ph == 2'd0)                 ph <= 2'd1;
                else if (scl_rise && ph == 2'd1 && !sda_i)  ph <= 2'd2;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        sda_pull_o = 1'b0;
        unique case (state)
            ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_pull_o = (ph == 2'd1);
            ST_RDATA:   sda_pull_o = ~tx_sr[7];
            ST_RD_ACK:  sda_pull_o = (ph == 2'd0) ? ~tx_sr[7] : 1'b0;
            default:    sda_pull_o = 1'b0;
        endcase
    end

    assign mem_addr_o  = busy_w ? prog_addr : ptr;
    assign mem_wdata_o = slot_data;
    assign mem_we_o    = prog_we;
    assign busy_o      = busy_w;

endmodule

// File: rtl/eep_twi_sva.sv
// Property checker attached to the slave controller.
module eep_twi_sva #(
    parameter int AW      = 8,
    parameter int PW      = 3,
    parameter int TWR_CYC = 2_500_000,
    localparam int CW = $clog2(TWR_CYC + 1) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          sda_pull_o,
    input logic          busy_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          bus_stop
);

    logic [CW-1:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (busy_o) begin
            busy_run <= busy_run + CW'(1);
        end else begin
            busy_run <= '0;
        end
    end

    // R3
    sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_pull_o));

    // R7
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !sda_pull_o);

    // R6
    we_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    // R6
    busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(bus_stop));

    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (busy_run < CW'(TWR_CYC)));

    // R4
    one_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o[AW-1:PW] == $past(mem_addr_o[AW-1:PW])));

endmodule

bind eep_twi_slave eep_twi_sva #(
    .AW      (AW),
    .PW      (PW),
    .TWR_CYC (TWR_CYC)
) sva_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_pull_o (sda_pull_o),
    .busy_o     (busy_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .bus_stop   (bus_stop)
);

// File: tb/eep_twi_slave_tb_top.sv
`timescale 1ns/1ps
module eep_twi_slave_tb_top;

    localparam int         MEMB = 128;
    localparam int         TWR  = 400;
    localparam logic [6:0] DEV  = 7'h50;
    localparam int         Q    = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_pull;
    logic [6:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       mem_we;
    logic [7:0] mem_rdata;
    logic       busy;
    wire        sda_bus = m_sda & ~sda_pull;

    logic [7:0] arr [MEMB];
    logic [7:0] exp_mem [MEMB];
    logic [7:0] wbuf [16];

    int vectors = 0;
    int errors  = 0;
    int run_len = 0;
    int last_len = 0;
    int pulses = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    eep_twi_slave #(
        .MEM_BYTES  (MEMB),
        .PAGE_BYTES (8),
        .DEV_ADDR   (DEV),
        .TWR_CYC    (TWR)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_bus),
        .sda_pull_o  (sda_pull),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_we_o    (mem_we),
        .mem_rdata_i (mem_rdata),
        .busy_o      (busy)
    );

    // array model with synchronous read
    always @(posedge clk) begin
        if (mem_we) arr[mem_addr] <= mem_wdata;
        mem_rdata <= arr[mem_addr];
    end

    // busy pulse length monitor
    always @(posedge clk) begin
        if (busy) begin
            run_len <= run_len + 1;
        end else if (run_len != 0) begin
            last_len <= run_len;
            run_len  <= 0;
            pulses   <= pulses + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] fill_val(input int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    task automatic m_start();
        m_sda = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        m_sda = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic m_stop();
        m_sda = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic put_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; tick(Q);
            scl = 1'b1;   tick(2 * Q);
            scl = 1'b0;   tick(Q);
        end
    endtask

    // sends a byte; acked = SDA low at both ends of the ninth high period
    task automatic put_byte(input logic [7:0] b, output bit acked);
        logic a0, a1;
        put_bits(b, 8);
        m_sda = 1'b1; tick(Q);
        scl = 1'b1;   tick(1);
        a0 = sda_bus; tick(2 * Q - 1);
        a1 = sda_bus;
        scl = 1'b0;   tick(Q);
        acked = !a0 && !a1;
    endtask

    task automatic get_byte(input bit ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            b[i] = sda_bus; tick(Q);
            scl = 1'b0;
        end
        tick(1);
        m_sda = ack ? 1'b0 : 1'b1; tick(Q);
        scl = 1'b1; tick(2 * Q);
        scl = 1'b0; tick(1);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic wait_idle();
        while (busy) tick(1);
        tick(2);
        chk(last_len == TWR, "R6 busy length", last_len, TWR);
    endtask

    // write of n bytes from wbuf starting at word address wa
    task automatic write_txn(input logic [7:0] wa, input int n, input bit wait_done);
        bit ack;
        logic [6:0] ea;
        m_start();
        put_byte({DEV, 1'b0}, ack);
        chk(ack, "R2 select ack", ack, 1);
        put_byte(wa, ack);
        chk(ack, "R3 address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            put_byte(wbuf[k], ack);
            chk(ack, "R3 data ack", ack, 1);
        end
        m_stop();
        for (int k = 0; k < n; k++) begin
            ea = {wa[6:3], 3'((wa[2:0] + k) & 7)};
            exp_mem[ea] = wbuf[k];
        end
        if (n > 0) begin
            chk(busy == 1'b1, "R6 busy after stop", busy, 1);
            if (wait_done) wait_idle();
        end else begin
            tick(8);
            chk(busy == 1'b0, "R11 no cycle for address-only write", busy, 0);
        end
    endtask

    // random read of n bytes starting at wa (pointer set with an address-only write)
    task automatic read_txn(input logic [7:0] wa, input int n, input string req);
        bit ack;
        logic [7:0] b;
        int a;
        m_start();
        put_byte({DEV, 1'b0}, ack);
        chk(ack, "R2 select ack", ack, 1);
        put_byte(wa, ack);
        chk(ack, "R3 address ack", ack, 1);
        m_start();
        put_byte({DEV, 1'b1}, ack);
        chk(ack, "R2 read select ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            a = (int'(wa[6:0]) + k) % MEMB;
            get_byte(k != n - 1, b);
            chk(b == exp_mem[a], req, b, exp_mem[a]);
        end
        m_stop();
    endtask

    initial begin
        bit ack;
        logic [7:0] b;
        int p0;
        for (int i = 0; i < MEMB; i++) begin
            arr[i] = 8'hFF;
            exp_mem[i] = 8'hFF;
        end
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1 reset state
        chk(sda_pull == 1'b0, "R1 sda released", sda_pull, 0);
        chk(busy == 1'b0, "R1 not busy", busy, 0);
        chk(mem_we == 1'b0, "R1 no write", mem_we, 0);

        // R4 R6: fill whole array with page writes
        for (int p = 0; p < MEMB / 8; p++) begin
            for (int k = 0; k < 8; k++) wbuf[k] = fill_val(p * 8 + k);
            write_txn(8'(p * 8), 8, 1'b1);
        end

        // R8: sequential read across the top of the array
        read_txn(8'h00, MEMB + 4, "R8 sequential read with wrap");
        read_txn(8'h7C, 9, "R8 read wrap from top");

        // R9: after a NACK the bus stays released
        m_start();
        put_byte({DEV, 1'b0}, ack);
        put_byte(8'h10, ack);
        m_start();
        put_byte({DEV, 1'b1}, ack);
        get_byte(1'b0, b);
        chk(b == exp_mem[16], "R8 single read", b, exp_mem[16]);
        get_byte(1'b0, b);
        chk(b == 8'hFF, "R9 released after nack", b, 8'hFF);
        m_stop();

        // R11: address-only write, then current-address read via read select
        write_txn(8'h55, 0, 1'b0);
        m_start();
        put_byte({DEV, 1'b1}, ack);
        chk(ack, "R11 read select ack", ack, 1);
        get_byte(1'b0, b);
        chk(b == exp_mem[8'h55], "R11 pointer kept", b, exp_mem[8'h55]);
        m_stop();

        // R4: upper word-address bit ignored with 128 bytes
        wbuf[0] = 8'h3C;
        write_txn(8'hC3, 1, 1'b1);
        read_txn(8'h40, 8, "R4 byte write, neighbours unchanged");

        // R4: in-page wrap
        for (int k = 0; k < 5; k++) wbuf[k] = 8'(8'hA0 + k);
        write_txn(8'h15, 5, 1'b1);
        read_txn(8'h10, 8, "R4 page wrap");

        // R5: FIFO overwrite with 11 bytes
        for (int k = 0; k < 11; k++) wbuf[k] = 8'(8'h60 + k * 3);
        write_txn(8'h22, 11, 1'b1);
        read_txn(8'h20, 8, "R5 overwrite keeps newest");

        // R7: no acknowledge while programming
        wbuf[0] = 8'h77;
        write_txn(8'h68, 1, 1'b0);
        m_start();
        put_byte({DEV, 1'b0}, ack);
        chk(!ack, "R7 no ack while busy", ack, 0);
        chk(busy == 1'b1, "R7 still busy during probe", busy, 1);
        m_stop();
        wait_idle();
        read_txn(8'h68, 1, "R7 write before probe kept");

        // R10: mid-byte STOP aborts
        p0 = pulses;
        m_start();
        put_byte({DEV, 1'b0}, ack);
        put_byte(8'h30, ack);
        put_byte(8'h11, ack);
        put_bits(8'h80, 3);
        m_stop();
        tick(TWR + 20);
        chk(pulses == p0 && !busy, "R10 stop abort no cycle", pulses - p0, 0);

        // R10: mid-byte START aborts
        m_start();
        put_byte({DEV, 1'b0}, ack);
        put_byte(8'h38, ack);
        put_byte(8'h22, ack);
        put_bits(8'hC0, 4);
        m_start();
        m_stop();
        tick(TWR + 20);
        chk(pulses == p0 && !busy, "R10 start abort no cycle", pulses - p0, 0);
        read_txn(8'h30, 16, "R10 aborted data not stored");

        // R2: sweep every other select address, both directions
        for (int a = 0; a < 128; a++) begin
            if (7'(a) != DEV) begin
                m_start();
                put_byte({7'(a), 1'(a & 1)}, ack);
                chk(!ack, "R2 foreign address ignored", ack, 0);
                m_stop();
            end
        end
        chk(pulses == p0, "R2 no cycle from foreign addresses", pulses - p0, 0);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vectors++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule